// File: doc/BRIEF.md
# Paged Effective Address Unit

This block turns a memory-reference instruction word and the program counter into the final operand address for a 12-bit machine with 4096 words of memory. Memory is treated as 32 fixed pages of 128 words. A 7-bit offset in the instruction is joined either to page zero or to the page that holds the program counter. When the instruction asks for indirection, the block reads one word at the formed address through its memory port and returns that word as the operand address.

Eight locations near the bottom of page zero, octal 010 to 017, act as auto-index pointers. An indirect reference to one of them adds one to the stored word, writes the new value back, and returns the incremented value. This gives software a pointer that steps forward each time it is used. A direct reference to the same locations treats them as ordinary words.

Requests arrive on a valid/ready channel that carries the instruction and the program counter. Results leave on a second valid/ready channel. The result valid signal is the done strobe. The block handles one request at a time. The request side stays not ready from the moment a request is accepted until its result has been taken, so back-pressure on the result side stalls new requests. A result that is offered stays unchanged until it is taken. The memory port is a plain synchronous single-port interface with one cycle of read latency.

Top module: `paged_ea_unit`

## Requirements
- R1: When the indirect flag (instruction bit 8, LSB = bit 0) is 0 and the page select (bit 7) is 0, the result address is zero in bits 11..7 with the offset (bits 6..0) in bits 6..0.
- R2: When the indirect flag is 0 and the page select is 1, the result address is program counter bits 11..7 joined to the offset in bits 6..0.
- R3: A direct reference raises res_valid in the first cycle after the request is accepted and makes no memory access.
- R4: An indirect reference to a formed address outside octal 010..017 issues exactly one memory read at the formed address. The word read is the result, and res_valid rises in the third cycle after acceptance.
- R5: An indirect reference whose formed address is in octal 010..017 reads that word, adds one modulo 4096, writes the sum back to the same address, and returns the sum, with res_valid in the third cycle after acceptance. 7777 octal becomes 0.
- R6: A direct reference to octal 010..017 writes no memory and leaves the stored word unchanged.
- R7: req_ready is high only when no request is in progress and no result is pending. While res_valid is high and res_ready is low, res_valid stays high and res_addr is unchanged. The result is released in the cycle that res_ready is high.
- R8: During reset and right after it, req_ready is 1, res_valid is 0 and mem_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_instr | input | 12 | Instruction word |
| req_pc | input | 12 | Program counter for the instruction |
| res_valid | output | 1 | Result address present (done strobe) |
| res_ready | input | 1 | Consumer takes the result |
| res_addr | output | 12 | Final operand address |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 12 | Write data |
| mem_rdata | input | 12 | Read data, valid one cycle after a read |

## Verification
The bench builds the block with its default parameters: 12-bit words, a 7-bit offset, and eight auto-index locations starting at octal 010. With these settings a 4096-word array covers the whole address space, so every page and the top-of-memory corner are reachable. Random instructions, program counters and memory contents are weighted toward the auto-index window. Directed cases cover wrap-around from 7777 octal, a current-page reference that lands in the auto-index window when the counter is on page zero, and the addresses just outside the window.

// File: rtl/paged_ea_pkg.sv
package paged_ea_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_CAPT = 2'd2,
    ST_DONE = 2'd3
  } ea_state_e;
endpackage

// File: rtl/paged_ea_form.sv
module paged_ea_form #(
  parameter int WORD_W   = 12,
  parameter int OFFS_W   = 7,
  parameter int IND_MSB  = 3,
  parameter int PAGE_MSB = 4,
  parameter int AI_BASE  = 8,
  parameter int AI_COUNT = 8
) (
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] pc,
  output logic [WORD_W-1:0] formed,
  output logic              indirect,
  output logic              autoidx
);
  localparam int PAGE_W  = WORD_W - OFFS_W;
  localparam int IND_IX  = WORD_W - 1 - IND_MSB;
  localparam int PAGE_IX = WORD_W - 1 - PAGE_MSB;
  localparam logic [WORD_W-1:0] AI_LO = WORD_W'(AI_BASE);
  localparam logic [WORD_W-1:0] AI_HI = WORD_W'(AI_BASE + AI_COUNT - 1);

  logic [PAGE_W-1:0] page_bits;
  logic              in_window;

  always_comb begin
    page_bits = instr[PAGE_IX] ? pc[WORD_W-1 -: PAGE_W] : '0;
    formed    = {page_bits, instr[OFFS_W-1:0]};
    indirect  = instr[IND_IX];
    in_window = (formed >= AI_LO) && (formed <= AI_HI);
    autoidx   = indirect && in_window;
  end
endmodule

// File: rtl/paged_ea_incr.sv
module paged_ea_incr #(
  parameter int WORD_W = 12
) (
  input  logic [WORD_W-1:0] a,
  output logic [WORD_W-1:0] y
);
  always_comb y = a + WORD_W'(1);
endmodule

// File: rtl/paged_ea_seq.sv
module paged_ea_seq
  import paged_ea_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [WORD_W-1:0] formed,
  input  logic              indirect,
  input  logic              autoidx,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [WORD_W-1:0] res_addr,
  output logic              mem_en,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic [WORD_W-1:0] rdata_inc
);
  ea_state_e         state_q;
  logic [WORD_W-1:0] ea_q;
  logic              ai_q;
  logic [WORD_W-1:0] res_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ea_q    <= '0;
      ai_q    <= 1'b0;
      res_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          ea_q <= formed;
          ai_q <= autoidx;
          if (indirect) begin
            state_q <= ST_READ;
          end else begin
            res_q   <= formed;
            state_q <= ST_DONE;
          end
        end
        ST_READ: state_q <= ST_CAPT;
        ST_CAPT: begin
          res_q   <= ai_q ? rdata_inc : mem_rdata;
          state_q <= ST_DONE;
        end
        ST_DONE: if (res_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready = (state_q == ST_IDLE);
    res_valid = (state_q == ST_DONE);
    res_addr  = res_q;
    mem_addr  = ea_q;
    mem_wdata = rdata_inc;
    mem_en    = (state_q == ST_READ) || ((state_q == ST_CAPT) && ai_q);
    mem_we    = (state_q == ST_CAPT) && ai_q;
  end
endmodule

// File: rtl/paged_ea_unit.sv
module paged_ea_unit #(
  parameter int WORD_W   = 12,
  parameter int OFFS_W   = 7,
  parameter int IND_MSB  = 3,
  parameter int PAGE_MSB = 4,
  parameter int AI_BASE  = 8,
  parameter int AI_COUNT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [WORD_W-1:0] req_instr,
  input  logic [WORD_W-1:0] req_pc,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [WORD_W-1:0] res_addr,
  output logic              mem_en,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata
);
  logic [WORD_W-1:0] formed;
  logic              indirect;
  logic              autoidx;
  logic [WORD_W-1:0] rdata_inc;

  paged_ea_form #(
    .WORD_W(WORD_W), .OFFS_W(OFFS_W), .IND_MSB(IND_MSB),
    .PAGE_MSB(PAGE_MSB), .AI_BASE(AI_BASE), .AI_COUNT(AI_COUNT)
  ) form_i (
    .instr(req_instr), .pc(req_pc), .formed(formed),
    .indirect(indirect), .autoidx(autoidx)
  );

  paged_ea_incr #(.WORD_W(WORD_W)) incr_i (
    .a(mem_rdata), .y(rdata_inc)
  );

  paged_ea_seq #(.WORD_W(WORD_W)) seq_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .formed(formed), .indirect(indirect), .autoidx(autoidx),
    .res_valid(res_valid), .res_ready(res_ready), .res_addr(res_addr),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rdata_inc(rdata_inc)
  );
endmodule

// File: rtl/paged_ea_unit_chk.sv
module paged_ea_unit_chk #(
  parameter int WORD_W   = 12,
  parameter int OFFS_W   = 7,
  parameter int IND_MSB  = 3,
  parameter int PAGE_MSB = 4,
  parameter int AI_BASE  = 8,
  parameter int AI_COUNT = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [WORD_W-1:0] req_instr,
  input logic [WORD_W-1:0] req_pc,
  input logic              res_valid,
  input logic              res_ready,
  input logic [WORD_W-1:0] res_addr,
  input logic              mem_en,
  input logic              mem_we,
  input logic [WORD_W-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_wdata,
  input logic [WORD_W-1:0] mem_rdata
);
  localparam int IND_IX  = WORD_W - 1 - IND_MSB;
  localparam int PAGE_IX = WORD_W - 1 - PAGE_MSB;
  localparam logic [WORD_W-1:0] AI_LO = WORD_W'(AI_BASE);
  localparam logic [WORD_W-1:0] AI_HI = WORD_W'(AI_BASE + AI_COUNT - 1);

  logic accept;
  assign accept = req_valid && req_ready;

  // R7
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_addr));

  // R7
  one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready);

  // R3
  direct_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !req_instr[IND_IX] |=> res_valid && !mem_en);

  // R1
  zero_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !req_instr[IND_IX] && !req_instr[PAGE_IX]
    |=> res_addr == {{(WORD_W-OFFS_W){1'b0}}, $past(req_instr[OFFS_W-1:0])});

  // R4
  ind_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_instr[IND_IX] |=> mem_en && !mem_we && !res_valid);

  // R5
  ai_writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> res_valid && res_addr == $past(mem_wdata));

  // R5
  ai_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en && mem_addr >= AI_LO && mem_addr <= AI_HI);
endmodule

bind paged_ea_unit paged_ea_unit_chk #(
  .WORD_W(WORD_W), .OFFS_W(OFFS_W), .IND_MSB(IND_MSB),
  .PAGE_MSB(PAGE_MSB), .AI_BASE(AI_BASE), .AI_COUNT(AI_COUNT)
) chk_i (.*);

// File: tb/paged_ea_unit_tb_top.sv
`timescale 1ns/1ps
module paged_ea_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [11:0] req_instr = '0;
  logic [11:0] req_pc = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [11:0] res_addr;
  logic        mem_en, mem_we;
  logic [11:0] mem_addr, mem_wdata;
  logic [11:0] mem_rdata = '0;
  logic [11:0] ram [4096];

  int n_tests = 0;
  int n_fail  = 0;
  int rd_cnt  = 0;
  int wr_cnt  = 0;

  always #5 clk = ~clk;

  paged_ea_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_instr(req_instr), .req_pc(req_pc), .res_valid(res_valid),
    .res_ready(res_ready), .res_addr(res_addr), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        ram[mem_addr] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= ram[mem_addr];
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0o expected=%0o", req, act, exp_v);
    end
  endtask

  function automatic logic [11:0] formed_of(input logic [11:0] ins, input logic [11:0] pc);
    logic [4:0] pg;
    pg = ins[7] ? pc[11:7] : 5'd0;
    return {pg, ins[6:0]};
  endfunction

  function automatic bit in_ai(input logic [11:0] a);
    return (a >= 12'o010) && (a <= 12'o017);
  endfunction

  task automatic run_txn(input logic [11:0] ins, input logic [11:0] pc, input int hold);
    logic [11:0] ea, old_w, exp_addr, exp_store, held;
    bit ind, ai;
    int lat, exp_lat, rd0, wr0;
    string areq;
    ea  = formed_of(ins, pc);
    ind = ins[8];
    ai  = ind && in_ai(ea);
    old_w = ram[ea];
    exp_addr  = !ind ? ea : (ai ? old_w + 12'd1 : old_w);
    exp_store = ai ? old_w + 12'd1 : old_w;
    exp_lat   = ind ? 3 : 1;
    areq = !ind ? (ins[7] ? "R2" : "R1") : (ai ? "R5" : "R4");

    @(negedge clk);
    check(req_ready == 1'b1, "R7 idle ready", int'(req_ready), 1);
    req_valid = 1'b1; req_instr = ins; req_pc = pc;
    rd0 = rd_cnt; wr0 = wr_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!res_valid && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    check(lat == exp_lat, ind ? "R4/R5 latency" : "R3 latency", lat, exp_lat);
    check(res_addr == exp_addr, areq, int'(res_addr), int'(exp_addr));
    check(rd_cnt - rd0 == (ind ? 1 : 0), ind ? "R4 read count" : "R3 read count",
          rd_cnt - rd0, ind ? 1 : 0);
    check(wr_cnt - wr0 == (ai ? 1 : 0), ai ? "R5 write count" : "R6 write count",
          wr_cnt - wr0, ai ? 1 : 0);
    check(req_ready == 1'b0, "R7 busy not ready", int'(req_ready), 0);
    held = res_addr;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check(res_valid && res_addr == held, "R7 hold", int'(res_addr), int'(held));
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check(res_valid == 1'b0, "R7 release", int'(res_valid), 0);
    check(ram[ea] == exp_store, ai ? "R5 stored" : "R6 stored", int'(ram[ea]), int'(exp_store));
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [11:0] ins, pc;
    void'($urandom(32'd20240611));
    for (int a = 0; a < 4096; a++) ram[a] = 12'($urandom);
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R8 ready in reset", int'(req_ready), 1);
    check(res_valid == 1'b0, "R8 no result in reset", int'(res_valid), 0);
    check(mem_en == 1'b0, "R8 no mem in reset", int'(mem_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && res_valid == 1'b0 && mem_en == 1'b0,
          "R8 after reset", int'({req_ready, res_valid, mem_en}), 3'b100);

    // R5 wrap from 7777 at the top of the window
    ram[12'o017] = 12'o7777;
    run_txn({3'b000, 1'b1, 1'b0, 7'o017}, 12'o4321, 1);
    // R5 stepping the same pointer again
    run_txn({3'b000, 1'b1, 1'b0, 7'o017}, 12'o4321, 0);
    // R6 direct reference to an auto-index word
    run_txn({3'b000, 1'b0, 1'b0, 7'o012}, 12'o2000, 0);
    // R5 current-page reference landing in the window from page zero
    run_txn({3'b000, 1'b1, 1'b1, 7'o014}, 12'o0123, 2);
    // R2 top of memory
    run_txn({3'b000, 1'b0, 1'b1, 7'o177}, 12'o7777, 0);
    // R4 just outside the window on both sides
    run_txn({3'b000, 1'b1, 1'b0, 7'o007}, 12'o0000, 0);
    run_txn({3'b000, 1'b1, 1'b0, 7'o020}, 12'o0000, 0);
    // R4 indirect through the current page
    run_txn({3'b000, 1'b1, 1'b1, 7'o055}, 12'o6543, 1);

    for (int t = 0; t < 400; t++) begin
      ins = 12'($urandom);
      pc  = 12'($urandom);
      if ($urandom % 3 == 0) begin
        ins[6:0] = 7'(8 + $urandom % 8);
        ins[7]   = 1'b0;
      end
      run_txn(ins, pc, int'($urandom % 3));
    end
    finish_run();
  end
endmodule